// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching translation entries from memory. A walk starts from a table base address, which software keeps in a base register. The top ten address bits pick a word in the directory that the base points to. That word either names the frame of a 4 MB page, which ends the walk, or names a second-level table. In the second case the next ten bits pick a word in that table, and that word names a 4 KB frame. The low twelve bits are the offset inside the 4 KB page.

Every level costs one word read over a request/response memory port. The request is held until the memory grants it, and the reply returns after any number of cycles. The walker does not cache entries. The result is a one-cycle pulse that carries either the physical address or a fault, together with the level at which the fault was found. A new walk is accepted only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, walk_ready is 1, done is 0 and mem_req is 0. While walk_ready is 1, mem_req stays 0.
- R2: The first read of a walk goes to table_base + 4 * lin_addr[31:22].
- R3: An entry is present when bit 0 is 1, and its bit 7 is the size flag. If the directory entry is present and its size flag is 0, the second read goes to {dir[31:12], 12'h000} + 4 * lin_addr[21:12]. If that second entry is present, phys_addr = {leaf[31:12], lin_addr[11:0]}, and the walk made exactly two reads.
- R4: A present directory entry with bit 7 set ends the walk after one read, with phys_addr = {dir[31:22], lin_addr[21:0]} and fault = 0.
- R5: A directory entry with bit 0 clear gives fault = 1, fault_level = 0 and phys_addr = 0, after exactly one read.
- R6: A second-level entry with bit 0 clear gives fault = 1, fault_level = 1 and phys_addr = 0, after two reads.
- R7: Once raised, mem_req stays high with a stable mem_addr until the cycle in which mem_gnt is 1. Each granted request gets exactly one read.
- R8: done is a pulse exactly one cycle wide. walk_ready is 0 from the cycle after a walk is accepted until done. A walk_valid seen while busy has no effect on the walk in progress.
- R9: Bit 7 of a second-level entry is ignored. Such an entry still maps a 4 KB page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Start a walk (taken only when walk_ready) |
| walk_ready | output | 1 | Walker idle |
| lin_addr | input | 32 | Linear address to translate |
| table_base | input | 32 | Directory base address |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Word address of the entry to read |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended on an entry that is not present |
| fault_level | output | 1 | 0 = directory, 1 = second level |
| phys_addr | output | 32 | Translated address (0 on fault) |

## Verification
The assertions assume that the memory grants only a raised request and returns exactly one reply per grant, always after the grant cycle and never while no read is outstanding. The bench's memory model keeps to this. It grants at random only when no reply is pending, drops the grant one cycle later, and returns the reply after a random 1 to 3 cycles. Stray starts are raised only while the walker is busy, and they are dropped before the walk ends.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT
  } walk_state_e;

  localparam logic LVL_DIR  = 1'b0;
  localparam logic LVL_LEAF = 1'b1;
endpackage

// File: rtl/pw_entry_decode.sv
module pw_entry_decode #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 12,
  parameter int BIG_OFS_W = 22,
  parameter int VALID_BIT = 0,
  parameter int SIZE_BIT  = 7
) (
  input  logic [ADDR_W-1:0]           entry,
  output logic                        present,
  output logic                        big,
  output logic [ADDR_W-1:0]           next_base,
  output logic [ADDR_W-OFS_W-1:0]     small_frame,
  output logic [ADDR_W-BIG_OFS_W-1:0] big_frame
);
  always_comb begin
    present     = entry[VALID_BIT];
    big         = entry[SIZE_BIT];
    small_frame = entry[ADDR_W-1:OFS_W];
    big_frame   = entry[ADDR_W-1:BIG_OFS_W];
    next_base   = {small_frame, {OFS_W{1'b0}}};
  end
endmodule

// File: rtl/pw_req_port.sv
module pw_req_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic              gnt,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              accepted
);
  assign accepted = req && gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      addr <= '0;
    end else if (launch) begin
      req  <= 1'b1;
      addr <= launch_addr;
    end else if (accepted) begin
      req  <= 1'b0;
    end
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (req && $stable(addr)));
  p_drop_after_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !launch) |=> !req);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int OFS_W     = 12,
  parameter int VALID_BIT = 0,
  parameter int SIZE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_valid,
  output logic              walk_ready,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [ADDR_W-1:0] phys_addr
);
  import pt_walker_pkg::*;

  localparam int BIG_OFS_W   = IDX_W + OFS_W;
  localparam int DIR_IDX_W   = ADDR_W - BIG_OFS_W;
  localparam int ENTRY_BYTES = ADDR_W / 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [ADDR_W-1:0] idx);
    return base + (idx << ENTRY_SHIFT);
  endfunction

  function automatic logic [ADDR_W-1:0] dir_index(input logic [ADDR_W-1:0] la);
    return ADDR_W'(la[ADDR_W-1:BIG_OFS_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] leaf_index(input logic [ADDR_W-1:0] la);
    return ADDR_W'(la[BIG_OFS_W-1:OFS_W]);
  endfunction

  walk_state_e state;
  logic [ADDR_W-1:0] lin_q;

  logic                        ent_present, ent_big;
  logic [ADDR_W-1:0]           ent_next_base;
  logic [ADDR_W-OFS_W-1:0]     ent_small_frame;
  logic [ADDR_W-BIG_OFS_W-1:0] ent_big_frame;

  pw_entry_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BIG_OFS_W(BIG_OFS_W),
    .VALID_BIT(VALID_BIT), .SIZE_BIT(SIZE_BIT)
  ) u_decode (
    .entry(mem_rdata), .present(ent_present), .big(ent_big),
    .next_base(ent_next_base), .small_frame(ent_small_frame),
    .big_frame(ent_big_frame)
  );

  // Named internal events
  logic start_walk, dir_resp, leaf_resp, go_leaf, launch, accepted;
  logic [ADDR_W-1:0] launch_addr;

  assign walk_ready = (state == ST_IDLE);
  assign start_walk = walk_ready && walk_valid;
  assign dir_resp   = (state == ST_DIR_WAIT) && mem_rvalid;
  assign leaf_resp  = (state == ST_LEAF_WAIT) && mem_rvalid;
  assign go_leaf    = dir_resp && ent_present && !ent_big;
  assign launch     = start_walk || go_leaf;

  always_comb begin
    if (start_walk) launch_addr = entry_addr(table_base, dir_index(lin_addr));
    else            launch_addr = entry_addr(ent_next_base, leaf_index(lin_q));
  end

  pw_req_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_addr(launch_addr),
    .gnt(mem_gnt), .req(mem_req), .addr(mem_addr), .accepted(accepted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      lin_q       <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= LVL_DIR;
      phys_addr   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_walk) begin
          lin_q <= lin_addr;
          state <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (accepted) state <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (dir_resp) begin
          if (!ent_present) begin
            done <= 1'b1; fault <= 1'b1; fault_level <= LVL_DIR;
            phys_addr <= '0; state <= ST_IDLE;
          end else if (ent_big) begin
            done <= 1'b1; fault <= 1'b0; fault_level <= LVL_DIR;
            phys_addr <= {ent_big_frame, lin_q[BIG_OFS_W-1:0]};
            state <= ST_IDLE;
          end else begin
            state <= ST_LEAF_REQ;
          end
        end
        ST_LEAF_REQ: if (accepted) state <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: if (leaf_resp) begin
          done <= 1'b1;
          fault_level <= LVL_LEAF;
          if (!ent_present) begin
            fault <= 1'b1; phys_addr <= '0;
          end else begin
            fault <= 1'b0; phys_addr <= {ent_small_frame, lin_q[OFS_W-1:0]};
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_walk |=> !walk_ready);
  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (phys_addr == '0));
  p_dir_fault_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_resp && !ent_present) |=> (done && fault && fault_level == LVL_DIR));
  p_leaf_fault_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (leaf_resp && !ent_present) |=> (done && fault && fault_level == LVL_LEAF));
  p_big_no_second_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_resp && ent_present && ent_big) |=> (!mem_req && walk_ready));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic walk_valid = 0, walk_ready;
  logic [31:0] lin_addr = 0, table_base = 0;
  logic mem_req, mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic done, fault, fault_level;
  logic [31:0] phys_addr;

  pt_walker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] rd_log [4];
  int rd_n = 0;

  bit pending = 0;
  int cnt = 0;
  logic [31:0] paddr = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Memory model: grant only when nothing outstanding, reply 1..3 cycles later
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 0;
    if (mem_gnt) begin
      mem_gnt = 0;
      pending = 1;
      if (rd_n < 4) rd_log[rd_n] = paddr;
      rd_n++;
    end else if (pending) begin
      if (cnt == 0) begin
        mem_rvalid = 1; mem_rdata = rd(paddr); pending = 0;
      end else cnt--;
    end else if (mem_req && rst_n) begin
      if ($urandom_range(0, 2) != 0) begin
        mem_gnt = 1; paddr = mem_addr; cnt = $urandom_range(0, 2);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent expected walk from the requirement text
  task automatic expect_walk(input logic [31:0] la, input logic [31:0] tb_base,
      output logic [31:0] ph, output bit flt, output bit lvl, output int nrd,
      output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] d, l;
    a1 = tb_base + {20'b0, la[31:22], 2'b00};
    d = rd(a1);
    a2 = 0; ph = 0; flt = 0; lvl = 0; nrd = 1;
    if (!d[0]) flt = 1;
    else if (d[7]) ph = {d[31:22], la[21:0]};
    else begin
      nrd = 2; lvl = 1;
      a2 = {d[31:12], 12'h000} + {20'b0, la[21:12], 2'b00};
      l = rd(a2);
      if (!l[0]) flt = 1;
      else ph = {l[31:12], la[11:0]};
    end
  endtask

  task automatic run_walk(input logic [31:0] la, input logic [31:0] b,
                          input bit stray, input string tag);
    logic [31:0] eph, ea1, ea2;
    bit efl, elv;
    int enr, t;
    expect_walk(la, b, eph, efl, elv, enr, ea1, ea2);
    rd_n = 0;
    @(negedge clk);
    walk_valid = 1; lin_addr = la; table_base = b;
    @(negedge clk);
    check(!walk_ready, "R8", "busy after accept", {31'b0, walk_ready}, 0);
    if (stray) begin
      lin_addr = ~la; table_base = b + 32'h40;
    end else walk_valid = 0;
    @(negedge clk);
    walk_valid = 0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) begin
      check(0, "R8", "watchdog walk", 0, 1);
      return;
    end
    check(fault == efl, tag, "fault", {31'b0, fault}, {31'b0, efl});
    check(phys_addr == eph, tag, "phys_addr", phys_addr, eph);
    check(rd_n == enr, "R7", "read count", rd_n, enr);
    check(rd_log[0] == ea1, "R2", "dir read addr", rd_log[0], ea1);
    if (enr == 2) check(rd_log[1] == ea2, "R3", "leaf read addr", rd_log[1], ea2);
    if (efl) check(fault_level == elv, elv ? "R6" : "R5", "fault_level",
                   {31'b0, fault_level}, {31'b0, elv});
    @(negedge clk);
    check(!done, "R8", "done pulse width", {31'b0, done}, 0);
    check(walk_ready && !mem_req, "R1", "idle after walk", {31'b0, walk_ready}, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        check(0, "R8", "global watchdog", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] base, la, pde_a, pte_a;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(walk_ready == 1 && done == 0 && mem_req == 0, "R1", "reset state",
          {29'b0, walk_ready, done, mem_req}, 32'h4);
    rst_n = 1;

    // R3: 4 KB page
    base = 32'h0001_0000; la = 32'h1234_5678;
    pde_a = base + {20'b0, la[31:22], 2'b00};
    mem[pde_a] = 32'h0020_0001;
    pte_a = 32'h0020_0000 + {20'b0, la[21:12], 2'b00};
    mem[pte_a] = 32'hABCD_E001;
    run_walk(la, base, 0, "R3");
    // R9: size flag in leaf ignored
    mem[pte_a] = 32'h5555_5081;
    run_walk(la, base, 0, "R9");
    // R6: leaf not present
    mem[pte_a] = 32'h5555_5080;
    run_walk(la, base, 0, "R6");
    // R4: large page
    mem[pde_a] = 32'hFFC0_0081;
    run_walk(la, base, 0, "R4");
    // R5: dir not present, even with size flag
    mem[pde_a] = 32'hFFC0_0080;
    run_walk(la, base, 0, "R5");
    // R8: stray start while busy ignored
    mem[pde_a] = 32'h0020_0001; mem[pte_a] = 32'h0777_7003;
    run_walk(la, base, 1, "R8");
    // Boundary: top index and max offset
    la = 32'hFFFF_FFFF;
    pde_a = base + 32'hFFC;
    mem[pde_a] = 32'h0030_0001;
    mem[32'h0030_0FFC] = 32'h1000_0001;
    run_walk(la, base, 0, "R3");

    for (int i = 0; i < 60; i++) begin
      logic [31:0] d;
      mem.delete();
      base = {$urandom_range(0, 255), 12'h000} & 32'h000F_F000;
      la = $urandom();
      d = {$urandom()} & 32'hFFFF_F000;
      d[0] = ($urandom_range(0, 7) != 0);
      d[7] = ($urandom_range(0, 3) == 0);
      pde_a = base + {20'b0, la[31:22], 2'b00};
      mem[pde_a] = d;
      pte_a = {d[31:12], 12'h000} + {20'b0, la[21:12], 2'b00};
      if (!mem.exists(pte_a)) mem[pte_a] = {$urandom()} | {31'b0, ($urandom_range(0, 5) != 0)};
      run_walk(la, base, ($urandom_range(0, 4) == 0), "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule